// File: doc/BRIEF.md
# Ping-Pong Page Capture Buffer

The block sits between a source that delivers one byte at a time, such as a serial receiver strobe, and a consumer that writes whole pages to slow storage. It holds two banks of 64 bytes. Incoming bytes always go into the active bank, one index after another. When the active bank holds a full page, the block raises a page-ready flag.

The consumer responds by pulsing a swap request. The swap makes the other bank active, so capture carries on there. The consumer then reads the full bank by index. When it has written the page out, it pulses drain-done. Drain-done clears the page-ready flag and advances a 16-bit destination page address by 64. That address starts at zero and wraps modulo 2^16.

If a byte arrives and the active bank has no free slot, the byte is dropped and a sticky overrun flag is set. This happens when both banks fill before the consumer has caught up.

Top module: `pingpong_capture`

## Requirements
- R1: After reset, activeBank is 0 and writeFlag, draining, overrun and destAddr are all 0.
- R2: Each accepted byte is stored at the next index of the active bank. The index starts at 0 after reset and after every accepted swap.
- R3: writeFlag rises in the cycle after the 64th byte of the active bank is stored. It stays high until an accepted drain-done.
- R4: A swapReq pulse is accepted only while writeFlag is 1 and draining is 0. An accepted swap toggles activeBank, resets the fill index and sets draining. Any other swapReq pulse leaves activeBank unchanged.
- R5: rdData combinationally shows the byte at index rdIdx of the bank that is not active.
- R6: A drainDone pulse is accepted only while draining is 1. An accepted drain-done clears draining and adds 64 to destAddr, modulo 2^16. It clears writeFlag unless the active bank is already full, in which case writeFlag stays 1. A drainDone pulse while draining is 0 changes nothing.
- R7: A byte that arrives while the active bank is full, with no accepted swap in the same cycle, is dropped. Such a byte sets overrun, which stays 1 until reset.
- R8: A byte that arrives in the same cycle as an accepted swap is stored at index 0 of the newly active bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Producer byte strobe |
| inData | input | 8 | Producer byte |
| swapReq | input | 1 | Consumer request to switch the active bank |
| drainDone | input | 1 | Consumer strobe marking that the page has been written out |
| rdIdx | input | 6 | Read index into the bank being drained |
| rdData | output | 8 | Byte at rdIdx of the bank that is not active |
| writeFlag | output | 1 | A full page is waiting or is being drained |
| draining | output | 1 | A swap was accepted and drain-done has not yet arrived |
| activeBank | output | 1 | Bank that receives incoming bytes |
| overrun | output | 1 | Sticky flag: a byte was dropped |
| destAddr | output | 16 | Destination page address, always a multiple of 64 |

## Verification
The bench aims at five corner cases:
- A byte arriving in the swap cycle. A design that handled it wrongly would drop the byte or place it at the old fill index.
- A second bank filling during a drain. A mistaken design would let the 65th byte overwrite index 0 or leave overrun low.
- Drain-done arriving while the other bank is already full. A mistaken design would lower writeFlag and lose that page.
- Premature swap and drain-done pulses. A careless design would let these toggle the bank or bump the address.
- A full run of 1024 drains. This checks that destAddr wraps to zero instead of saturating or carrying past bit 15.

// File: rtl/pingpong_pkg.sv
package pingpong_pkg;
  typedef struct packed {
    logic wrEn;
    logic wrBank;
    logic [5:0] wrIdx;
    logic bumpAddr;
  } ppStrobes_t;
endpackage

// File: rtl/pingpong_ctrl.sv
module pingpong_ctrl
  import pingpong_pkg::*;
#(
  parameter int BANK_BYTES = 64,
  localparam int IDX_W = $clog2(BANK_BYTES)
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic swapReq,
  input  logic drainDone,
  output ppStrobes_t strobes,
  output logic writeFlag,
  output logic draining,
  output logic activeBank,
  output logic overrun
);
  localparam logic [IDX_W:0] FULL_CNT = (IDX_W+1)'(BANK_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BANK_BYTES - 1);

  logic [IDX_W:0] fillCnt;
  logic bankFull, swapOk, doneOk, wrEn, fillEvent;
  logic [IDX_W-1:0] wrIdx;

  assign bankFull  = (fillCnt == FULL_CNT);
  assign swapOk    = swapReq && writeFlag && !draining;
  assign doneOk    = drainDone && draining;
  assign wrEn      = inValid && (swapOk || !bankFull);
  assign wrIdx     = swapOk ? '0 : fillCnt[IDX_W-1:0];
  assign fillEvent = wrEn && (wrIdx == LAST_IDX);

  always_comb begin
    strobes          = '0;
    strobes.wrEn     = wrEn;
    strobes.wrBank   = swapOk ? ~activeBank : activeBank;
    strobes.wrIdx    = 6'(wrIdx);
    strobes.bumpAddr = doneOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt    <= '0;
      activeBank <= 1'b0;
      writeFlag  <= 1'b0;
      draining   <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      if (swapOk) begin
        activeBank <= ~activeBank;
        fillCnt    <= inValid ? (IDX_W+1)'(1) : '0;
        draining   <= 1'b1;
      end else if (wrEn) begin
        fillCnt <= fillCnt + 1'b1;
      end
      if (doneOk) draining <= 1'b0;
      if (fillEvent)   writeFlag <= 1'b1;
      else if (doneOk) writeFlag <= bankFull;
      if (inValid && !wrEn) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/pingpong_dpath.sv
module pingpong_dpath
  import pingpong_pkg::*;
#(
  parameter int BANK_BYTES = 64,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  localparam int IDX_W = $clog2(BANK_BYTES)
) (
  input  logic clk,
  input  logic rstN,
  input  ppStrobes_t strobes,
  input  logic [DATA_W-1:0] inData,
  input  logic rdBank,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] destAddr
);
  logic [DATA_W-1:0] mem [2][BANK_BYTES];

  always_ff @(posedge clk) begin
    if (strobes.wrEn) mem[strobes.wrBank][strobes.wrIdx[IDX_W-1:0]] <= inData;
  end

  assign rdData = mem[rdBank][rdIdx];

  always_ff @(posedge clk) begin
    if (!rstN) destAddr <= '0;
    else if (strobes.bumpAddr) destAddr <= destAddr + ADDR_W'(BANK_BYTES);
  end
endmodule

// File: rtl/pingpong_capture.sv
module pingpong_capture
  import pingpong_pkg::*;
#(
  parameter int BANK_BYTES = 64,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  localparam int IDX_W = $clog2(BANK_BYTES)
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic swapReq,
  input  logic drainDone,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic writeFlag,
  output logic draining,
  output logic activeBank,
  output logic overrun,
  output logic [ADDR_W-1:0] destAddr
);
  ppStrobes_t strobes;

  pingpong_ctrl #(.BANK_BYTES(BANK_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .swapReq(swapReq),
    .drainDone(drainDone), .strobes(strobes), .writeFlag(writeFlag),
    .draining(draining), .activeBank(activeBank), .overrun(overrun)
  );

  pingpong_dpath #(.BANK_BYTES(BANK_BYTES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inData(inData),
    .rdBank(~activeBank), .rdIdx(rdIdx), .rdData(rdData), .destAddr(destAddr)
  );
endmodule

// File: rtl/pingpong_capture_chk.sv
module pingpong_capture_chk #(
  parameter int BANK_BYTES = 64,
  parameter int ADDR_W = 16
) (
  input logic clk,
  input logic rstN,
  input logic swapReq,
  input logic drainDone,
  input logic writeFlag,
  input logic draining,
  input logic activeBank,
  input logic overrun,
  input logic [ADDR_W-1:0] destAddr
);
  // R4
  swap_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swapReq && writeFlag && !draining) |=> (activeBank != $past(activeBank)) && draining);
  // R4
  swap_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(swapReq && writeFlag && !draining) |=> $stable(activeBank));
  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (drainDone && draining) |=> destAddr == $past(destAddr) + ADDR_W'(BANK_BYTES));
  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(drainDone && draining) |=> $stable(destAddr));
  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (writeFlag && !(drainDone && draining)) |=> writeFlag);
  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);
endmodule

bind pingpong_capture pingpong_capture_chk #(.BANK_BYTES(BANK_BYTES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .swapReq(swapReq), .drainDone(drainDone),
  .writeFlag(writeFlag), .draining(draining), .activeBank(activeBank),
  .overrun(overrun), .destAddr(destAddr)
);

// File: tb/tb_pingpong_capture.sv
module tb_pingpong_capture;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inData = '0;
  logic swapReq = 1'b0;
  logic drainDone = 1'b0;
  logic [5:0] rdIdx = '0;
  logic [7:0] rdData;
  logic writeFlag, draining, activeBank, overrun;
  logic [15:0] destAddr;
  int nTests = 0;
  int nFail = 0;
  logic [15:0] expAddr = '0;

  always #5 clk = ~clk;

  pingpong_capture dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .swapReq(swapReq), .drainDone(drainDone), .rdIdx(rdIdx), .rdData(rdData),
    .writeFlag(writeFlag), .draining(draining), .activeBank(activeBank),
    .overrun(overrun), .destAddr(destAddr)
  );

  function automatic logic [7:0] pat(int seed, int i);
    return 8'((seed * 37 + i * 13 + 5) & 255);
  endfunction

  task automatic check(string tag, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(logic [7:0] d);
    inValid = 1'b1; inData = d;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic fill(int seed, int first, int last);
    for (int i = first; i <= last; i++) push(pat(seed, i));
  endtask

  task automatic pulseSwap(logic withByte, logic [7:0] d);
    swapReq = 1'b1; inValid = withByte; inData = d;
    @(negedge clk);
    swapReq = 1'b0; inValid = 1'b0;
  endtask

  task automatic pulseDone();
    drainDone = 1'b1;
    @(negedge clk);
    drainDone = 1'b0;
  endtask

  task automatic readBank(int seed, int firstIdx, string tag);
    for (int i = firstIdx; i < 64; i++) begin
      rdIdx = 6'(i); #1;
      check(tag, rdData, pat(seed, i));
    end
  endtask

  initial begin
    #1_800_000;
    nFail++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 activeBank", activeBank, 0);
    check("R1 writeFlag", writeFlag, 0);
    check("R1 draining", draining, 0);
    check("R1 overrun", overrun, 0);
    check("R1 destAddr", destAddr, 0);

    // premature controls ignored
    fill(1, 0, 9);
    pulseSwap(1'b0, 8'h00);
    check("R4 early swap ignored", activeBank, 0);
    pulseDone();
    check("R6 early done ignored", destAddr, 0);
    fill(1, 10, 62);
    check("R3 flag low at 63", writeFlag, 0);
    fill(1, 63, 63);
    check("R3 flag high at 64", writeFlag, 1);

    // swap with a byte in the same cycle
    pulseSwap(1'b1, 8'hA5);
    check("R4 swap toggles", activeBank, 1);
    check("R4 swap sets draining", draining, 1);
    check("R3 flag held in drain", writeFlag, 1);
    readBank(1, 0, "R5 R2 bank0 data");
    pulseDone();
    expAddr += 16'd64;
    check("R6 addr +64", destAddr, expAddr);
    check("R6 flag cleared", writeFlag, 0);
    check("R6 draining cleared", draining, 0);

    fill(2, 1, 63);
    check("R3 bank1 full", writeFlag, 1);
    pulseSwap(1'b0, 8'h00);
    check("R4 swap back", activeBank, 0);
    rdIdx = 6'd0; #1;
    check("R8 swap-cycle byte at idx0", rdData, 8'hA5);
    readBank(2, 1, "R2 bank1 data");
    pulseDone();
    expAddr += 16'd64;
    check("R6 addr second drain", destAddr, expAddr);

    // overrun: both banks full before drain completes
    fill(3, 0, 63);
    pulseSwap(1'b0, 8'h00);
    fill(4, 0, 63);
    check("R7 no overrun yet", overrun, 0);
    push(8'hEE);
    check("R7 overrun set", overrun, 1);
    pulseDone();
    expAddr += 16'd64;
    check("R6 addr third drain", destAddr, expAddr);
    check("R6 flag stays when other bank full", writeFlag, 1);
    pulseSwap(1'b0, 8'h00);
    check("R4 swap after overrun", activeBank, 0);
    readBank(4, 0, "R7 dropped byte not stored");
    pulseDone();
    expAddr += 16'd64;
    check("R6 flag cleared empty bank", writeFlag, 0);
    check("R7 overrun sticky", overrun, 1);

    // address sweep to wrap
    for (int k = 0; k < 1020; k++) begin
      fill(k & 7, 0, 63);
      pulseSwap(1'b0, 8'h00);
      pulseDone();
      expAddr += 16'd64;
      check("R6 addr sweep", destAddr, expAddr);
    end
    check("R6 addr wrapped to zero", destAddr, 0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule